// File: doc/BRIEF.md
# Monochrome LCD Command Decoder

This block is the controller-side logic of a small page-organized monochrome LCD. Each byte comes in from a serial front end with a one-cycle valid strobe and a data/command flag. A byte with the flag low is an instruction. A byte with the flag high is pixel data, and it is stored in an on-chip display RAM of 102 columns by 9 pages, each entry holding eight vertical pixels.

The instruction set has two banks. A function-set instruction, which is decoded the same way in both banks, selects the bank through an extended-mode bit. The same opcode byte therefore has a different effect depending on that bit:
- In the basic bank, instructions move the column and page pointers and choose the display mode.
- In the extended bank, instructions load the bias, the contrast and the start display line.

After every data byte the pointers advance on their own, either column-first or page-first. A combinational read port exposes the display RAM, and every control register is brought out on its own port, so a scan engine or a testbench can observe the state.

Top module: `lcd_cmd_decoder`

## Requirements
- R1: A synchronous reset (srst high at a clock edge) clears every control register to 0: extended mode off, power-down off, horizontal addressing, bias, contrast, display mode, start line, column pointer and page pointer. The display RAM keeps its contents.
- R2: In either bank, a command 0b00100_P_V_H sets pwr_down=P, vert_addr=V and ext_mode=H. ext_mode changes on no other byte.
- R3: With ext_mode=1, a command 0b00010_bbb loads bias with bbb. A command with bit 7 set loads contrast with bits 6:0 and leaves the column pointer unchanged.
- R4: With ext_mode=1, a command 0b0000010_s loads start_line bit 6 with s. A command 0b01_ssssss loads start_line bits 5:0.
- R5: With ext_mode=0, a command with bit 7 set loads the column pointer with bits 6:0 when that value is 101 or less, and is ignored otherwise.
- R6: With ext_mode=0, a command 0b0100_yyyy loads the page pointer when yyyy is 8 or less, and is ignored otherwise. A command 0b00001_D_0_E sets disp_mode to {D,E}.
- R7: A valid byte with byte_dc=1 is written to the RAM at the current (column, page). rd_data shows it at the matching rd_col/rd_page after that clock edge.
- R8: With vert_addr=0, each data byte increments the column pointer. After column 101 the column pointer returns to 0 and the page pointer increments, and the page pointer goes from 8 back to 0.
- R9: With vert_addr=1, each data byte increments the page pointer. After page 8 the page pointer returns to 0 and the column pointer increments, and the column pointer goes from 101 back to 0.
- R10: Commands that belong only to the other bank, commands that match no pattern, and bytes presented with byte_vld low change no register.
- R11: rd_data is 0 when rd_col is above 101 or rd_page is above 8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| srst | input | 1 | Synchronous reset, active high |
| byte_vld | input | 1 | Byte strobe, one cycle per byte |
| byte_dc | input | 1 | 1 = display data, 0 = command |
| byte_in | input | 8 | Incoming byte |
| rd_col | input | 7 | Read column address |
| rd_page | input | 4 | Read page address |
| rd_data | output | 8 | RAM byte at rd_col/rd_page |
| ext_mode | output | 1 | Extended-bank select |
| pwr_down | output | 1 | Power-down flag |
| vert_addr | output | 1 | 1 = page-first auto-increment |
| bias | output | 3 | Bias level |
| contrast | output | 7 | Contrast value |
| disp_mode | output | 2 | Display mode {D,E} |
| start_line | output | 7 | Start display line |
| x_ptr | output | 7 | Column pointer |
| y_ptr | output | 4 | Page pointer |

## Verification
The hardest state to reach is the double wrap. A data byte written at column 101 on page 8 sends both pointers back to the origin, and the page-first mode has its own mirror of that case. The stimulus does not stream roughly 900 bytes to get there. Instead it loads both pointers directly with basic-bank address commands and then sends a single data byte, and it repeats this after switching to vertical addressing. The bank dependence is covered by sending the same opcode byte while the extended bit is set and again while it is clear, and checking at the ports which register moved.

// File: rtl/lcd_pkg.sv
package lcd_pkg;
    typedef enum logic [3:0] {
        CK_NONE,
        CK_FSET,
        CK_BIAS,
        CK_VOP,
        CK_SLHI,
        CK_SLLO,
        CK_XSET,
        CK_YSET,
        CK_DCTL
    } cmd_kind_e;
endpackage

// File: rtl/lcd_cmd_decode.sv
module lcd_cmd_decode
    import lcd_pkg::*;
#(
    parameter int COLS  = 102,
    parameter int PAGES = 9
) (
    input  logic [7:0] op,
    input  logic       ext,
    output cmd_kind_e  kind
);
    localparam logic [6:0] XMAX = 7'(COLS - 1);
    localparam logic [3:0] YMAX = 4'(PAGES - 1);

    always_comb begin
        kind = CK_NONE;
        if (op[7:3] == 5'b00100) begin
            kind = CK_FSET;
        end else if (ext) begin
            if (op[7])                          kind = CK_VOP;
            else if (op[7:6] == 2'b01)          kind = CK_SLLO;
            else if (op[7:3] == 5'b00010)       kind = CK_BIAS;
            else if (op[7:1] == 7'b0000010)     kind = CK_SLHI;
        end else begin
            if (op[7]) begin
                if (op[6:0] <= XMAX)            kind = CK_XSET;
            end else if (op[7:4] == 4'b0100) begin
                if (op[3:0] <= YMAX)            kind = CK_YSET;
            end else if (op[7:3] == 5'b00001 && !op[1]) begin
                kind = CK_DCTL;
            end
        end
    end
endmodule

// File: rtl/lcd_addr_step.sv
module lcd_addr_step #(
    parameter int COLS  = 102,
    parameter int PAGES = 9,
    parameter int XW    = 7,
    parameter int YW    = 4
) (
    input  logic [XW-1:0] x,
    input  logic [YW-1:0] y,
    input  logic          vert,
    output logic [XW-1:0] nx,
    output logic [YW-1:0] ny
);
    localparam logic [XW-1:0] XLAST = XW'(COLS - 1);
    localparam logic [YW-1:0] YLAST = YW'(PAGES - 1);

    logic [XW-1:0] x_inc;
    logic [YW-1:0] y_inc;

    assign x_inc = (x == XLAST) ? '0 : x + 1'b1;
    assign y_inc = (y == YLAST) ? '0 : y + 1'b1;

    always_comb begin
        if (vert) begin
            ny = y_inc;
            nx = (y == YLAST) ? x_inc : x;
        end else begin
            nx = x_inc;
            ny = (x == XLAST) ? y_inc : y;
        end
    end
endmodule

// File: rtl/lcd_dram.sv
module lcd_dram #(
    parameter int COLS  = 102,
    parameter int PAGES = 9,
    parameter int XW    = 7,
    parameter int YW    = 4
) (
    input  logic          clk,
    input  logic          we,
    input  logic [XW-1:0] wx,
    input  logic [YW-1:0] wy,
    input  logic [7:0]    wd,
    input  logic [XW-1:0] rx,
    input  logic [YW-1:0] ry,
    output logic [7:0]    rd
);
    localparam int DEPTH = COLS * PAGES;
    localparam int AW    = $clog2(DEPTH);
    localparam logic [XW-1:0] XLAST = XW'(COLS - 1);
    localparam logic [YW-1:0] YLAST = YW'(PAGES - 1);

    logic [7:0]    mem [DEPTH];
    logic [AW-1:0] widx;
    logic [AW-1:0] ridx;

    assign widx = AW'(wy) * AW'(COLS) + AW'(wx);
    assign ridx = AW'(ry) * AW'(COLS) + AW'(rx);

    always_ff @(posedge clk) begin
        if (we) mem[widx] <= wd;
    end

    assign rd = (rx <= XLAST && ry <= YLAST) ? mem[ridx] : 8'h00;
endmodule

// File: rtl/lcd_cmd_decoder.sv
module lcd_cmd_decoder
    import lcd_pkg::*;
#(
    parameter int COLS  = 102,
    parameter int PAGES = 9,
    localparam int XW   = $clog2(COLS),
    localparam int YW   = $clog2(PAGES)
) (
    input  logic          clk,
    input  logic          srst,
    input  logic          byte_vld,
    input  logic          byte_dc,
    input  logic [7:0]    byte_in,
    input  logic [XW-1:0] rd_col,
    input  logic [YW-1:0] rd_page,
    output logic [7:0]    rd_data,
    output logic          ext_mode,
    output logic          pwr_down,
    output logic          vert_addr,
    output logic [2:0]    bias,
    output logic [6:0]    contrast,
    output logic [1:0]    disp_mode,
    output logic [6:0]    start_line,
    output logic [XW-1:0] x_ptr,
    output logic [YW-1:0] y_ptr
);
    localparam logic [XW-1:0] XLAST = XW'(COLS - 1);
    localparam logic [YW-1:0] YLAST = YW'(PAGES - 1);

    typedef struct packed {
        logic          ext;
        logic          pd;
        logic          vert;
        logic [2:0]    bias;
        logic [6:0]    vop;
        logic [1:0]    dmode;
        logic [6:0]    sline;
        logic [XW-1:0] x;
        logic [YW-1:0] y;
    } st_t;

    st_t           st_d, st_q;
    cmd_kind_e     kind;
    logic [XW-1:0] nx;
    logic [YW-1:0] ny;
    logic          we_d;

    lcd_cmd_decode #(.COLS(COLS), .PAGES(PAGES)) u_dec (
        .op   (byte_in),
        .ext  (st_q.ext),
        .kind (kind)
    );

    lcd_addr_step #(.COLS(COLS), .PAGES(PAGES), .XW(XW), .YW(YW)) u_step (
        .x    (st_q.x),
        .y    (st_q.y),
        .vert (st_q.vert),
        .nx   (nx),
        .ny   (ny)
    );

    lcd_dram #(.COLS(COLS), .PAGES(PAGES), .XW(XW), .YW(YW)) u_ram (
        .clk (clk),
        .we  (we_d),
        .wx  (st_q.x),
        .wy  (st_q.y),
        .wd  (byte_in),
        .rx  (rd_col),
        .ry  (rd_page),
        .rd  (rd_data)
    );

    always_comb begin
        st_d = st_q;
        we_d = 1'b0;
        if (byte_vld) begin
            if (byte_dc) begin
                we_d   = 1'b1;
                st_d.x = nx;
                st_d.y = ny;
            end else begin
                case (kind)
                    CK_FSET: begin
                        st_d.ext  = byte_in[0];
                        st_d.vert = byte_in[1];
                        st_d.pd   = byte_in[2];
                    end
                    CK_BIAS: st_d.bias        = byte_in[2:0];
                    CK_VOP:  st_d.vop         = byte_in[6:0];
                    CK_SLHI: st_d.sline[6]    = byte_in[0];
                    CK_SLLO: st_d.sline[5:0]  = byte_in[5:0];
                    CK_XSET: st_d.x           = byte_in[XW-1:0];
                    CK_YSET: st_d.y           = byte_in[YW-1:0];
                    CK_DCTL: st_d.dmode       = {byte_in[2], byte_in[0]};
                    default: ;
                endcase
            end
        end
    end

    always_ff @(posedge clk) begin
        if (srst) st_q <= '0;
        else      st_q <= st_d;
    end

    assign ext_mode   = st_q.ext;
    assign pwr_down   = st_q.pd;
    assign vert_addr  = st_q.vert;
    assign bias       = st_q.bias;
    assign contrast   = st_q.vop;
    assign disp_mode  = st_q.dmode;
    assign start_line = st_q.sline;
    assign x_ptr      = st_q.x;
    assign y_ptr      = st_q.y;

    assert_reset_clear_R1: assert property (@(posedge clk)
        srst |=> (st_q == '0));

    assert_ext_only_fset_R2: assert property (@(posedge clk) disable iff (srst)
        !(byte_vld && !byte_dc && byte_in[7:3] == 5'b00100) |=> $stable(st_q.ext));

    assert_ptr_range_R8: assert property (@(posedge clk) disable iff (srst)
        (st_q.x <= XLAST) && (st_q.y <= YLAST));

    assert_hstep_R8: assert property (@(posedge clk) disable iff (srst)
        (byte_vld && byte_dc && !st_q.vert && st_q.x != XLAST)
        |=> (st_q.x == $past(st_q.x) + 1'b1) && $stable(st_q.y));

    assert_vstep_R9: assert property (@(posedge clk) disable iff (srst)
        (byte_vld && byte_dc && st_q.vert && st_q.y != YLAST)
        |=> (st_q.y == $past(st_q.y) + 1'b1) && $stable(st_q.x));

    assert_bank_ignore_R10: assert property (@(posedge clk) disable iff (srst)
        (byte_vld && !byte_dc && !st_q.ext && byte_in[7:3] == 5'b00010)
        |=> $stable(st_q.bias));

    assert_idle_hold_R10: assert property (@(posedge clk) disable iff (srst)
        !byte_vld |=> $stable(st_q));
endmodule

// File: tb/lcd_cmd_decoder_bench.sv
`timescale 1ns/1ps
module lcd_cmd_decoder_bench;
    logic       clk = 1'b0;
    logic       srst = 1'b1;
    logic       byte_vld = 1'b0;
    logic       byte_dc = 1'b0;
    logic [7:0] byte_in = 8'h00;
    logic [6:0] rd_col = 7'd0;
    logic [3:0] rd_page = 4'd0;
    logic [7:0] rd_data;
    logic       ext_mode, pwr_down, vert_addr;
    logic [2:0] bias;
    logic [6:0] contrast;
    logic [1:0] disp_mode;
    logic [6:0] start_line;
    logic [6:0] x_ptr;
    logic [3:0] y_ptr;

    int  n_cmp = 0;
    int  n_bad = 0;
    bit  done = 1'b0;

    always #2.5 clk = ~clk;

    lcd_cmd_decoder u_lcd_cmd_decoder (
        .clk(clk), .srst(srst), .byte_vld(byte_vld), .byte_dc(byte_dc),
        .byte_in(byte_in), .rd_col(rd_col), .rd_page(rd_page), .rd_data(rd_data),
        .ext_mode(ext_mode), .pwr_down(pwr_down), .vert_addr(vert_addr),
        .bias(bias), .contrast(contrast), .disp_mode(disp_mode),
        .start_line(start_line), .x_ptr(x_ptr), .y_ptr(y_ptr)
    );

    // {dc, byte, expected x, expected y, expected ext}
    localparam int NV = 17;
    localparam logic [20:0] VEC [NV] = '{
        {1'b0, 8'h85, 7'd5,   4'd0, 1'b0},  // R5 set column 5
        {1'b0, 8'h43, 7'd5,   4'd3, 1'b0},  // R6 set page 3
        {1'b0, 8'h21, 7'd5,   4'd3, 1'b1},  // R2 enter extended bank
        {1'b0, 8'h85, 7'd5,   4'd3, 1'b1},  // R3 contrast, column untouched
        {1'b0, 8'h20, 7'd5,   4'd3, 1'b0},  // R2 back to basic bank
        {1'b1, 8'hAA, 7'd6,   4'd3, 1'b0},  // R7 R8 data at (5,3)
        {1'b0, 8'hE5, 7'd101, 4'd3, 1'b0},  // R5 column 101
        {1'b1, 8'h55, 7'd0,   4'd4, 1'b0},  // R8 column wrap, page step
        {1'b0, 8'hEE, 7'd0,   4'd4, 1'b0},  // R5 column 110 ignored
        {1'b0, 8'h49, 7'd0,   4'd4, 1'b0},  // R6 page 9 ignored
        {1'b0, 8'h48, 7'd0,   4'd8, 1'b0},  // R6 page 8
        {1'b0, 8'hE5, 7'd101, 4'd8, 1'b0},  // R5 column 101
        {1'b1, 8'h11, 7'd0,   4'd0, 1'b0},  // R8 double wrap
        {1'b0, 8'h22, 7'd0,   4'd0, 1'b0},  // R2 vertical addressing
        {1'b0, 8'h48, 7'd0,   4'd8, 1'b0},  // R6 page 8
        {1'b1, 8'h22, 7'd1,   4'd0, 1'b0},  // R9 page wrap, column step
        {1'b1, 8'h33, 7'd1,   4'd1, 1'b0}   // R9 page step
    };

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic send(input logic dc, input logic [7:0] b);
        @(negedge clk);
        byte_vld = 1'b1;
        byte_dc  = dc;
        byte_in  = b;
        @(negedge clk);
        byte_vld = 1'b0;
    endtask

    task automatic rd_check(input string tag, input logic [6:0] c, input logic [3:0] p,
                            input logic [7:0] exp);
        rd_col  = c;
        rd_page = p;
        #1;
        check(tag, {24'd0, rd_data}, {24'd0, exp});
    endtask

    task automatic all_zero(input string tag);
        check(tag, {ext_mode, pwr_down, vert_addr, bias, contrast, disp_mode,
                    start_line, x_ptr, y_ptr}, 32'd0);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        srst = 1'b0;
        @(negedge clk);
        all_zero("R1 reset state");

        for (int i = 0; i < NV; i++) begin
            send(VEC[i][20], VEC[i][19:12]);
            check($sformatf("table row %0d x/y/ext", i),
                  {20'd0, x_ptr, y_ptr, ext_mode}, {20'd0, VEC[i][11:0]});
        end

        check("R3 contrast value", {25'd0, contrast}, 32'd5);
        rd_check("R7 ram (5,3)",   7'd5,   4'd3, 8'hAA);
        rd_check("R8 ram (101,3)", 7'd101, 4'd3, 8'h55);
        rd_check("R8 ram (101,8)", 7'd101, 4'd8, 8'h11);
        rd_check("R9 ram (0,8)",   7'd0,   4'd8, 8'h22);
        rd_check("R9 ram (1,0)",   7'd1,   4'd0, 8'h33);
        rd_check("R11 column 102", 7'd102, 4'd0, 8'h00);
        rd_check("R11 page 9",     7'd0,   4'd9, 8'h00);

        send(1'b0, 8'h21);
        send(1'b0, 8'h16);
        check("R3 bias", {29'd0, bias}, 32'd6);
        send(1'b0, 8'h05);
        check("R4 start line high", {25'd0, start_line}, 32'd64);
        send(1'b0, 8'h6A);
        check("R4 start line low", {25'd0, start_line}, 32'h6A);
        send(1'b0, 8'hE5);
        check("R3 contrast reload", {25'd0, contrast}, 32'h65);
        check("R10 column kept in ext bank", {25'd0, x_ptr}, 32'd1);
        send(1'b0, 8'h0C);
        check("R10 display cmd ignored in ext bank", {30'd0, disp_mode}, 32'd0);

        send(1'b0, 8'h20);
        send(1'b0, 8'h0C);
        check("R6 display mode", {30'd0, disp_mode}, 32'd2);
        send(1'b0, 8'h13);
        check("R10 bias cmd ignored in basic bank", {29'd0, bias}, 32'd6);
        send(1'b0, 8'h40);
        check("R4 R10 start line kept in basic bank", {25'd0, start_line}, 32'h6A);

        @(negedge clk);
        byte_dc = 1'b0;
        byte_in = 8'h21;
        @(negedge clk);
        check("R10 byte_vld low ignored", {31'd0, ext_mode}, 32'd0);

        send(1'b0, 8'h26);
        check("R2 function set pd/vert/ext", {29'd0, pwr_down, vert_addr, ext_mode}, 32'b110);

        srst = 1'b1;
        @(negedge clk);
        srst = 1'b0;
        all_zero("R1 reset clears registers");

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule